// File: doc/BRIEF.md
# Bulk Pipe Command and Halt Controller

This block holds the command and status logic for a single bulk or interrupt pipe of a USB controller that can act as host or as peripheral. A processor writes a command byte to queue the buffered packet for sending, to halt the pipe, or to reset it. It reads back a status byte that reports the halt state, a STALL answered by the far side, and low-level transmission errors. The block keeps the DATA0/DATA1 data toggle for the pipe. It drives a simple request/handshake interface towards a packet engine, and it raises a sticky interrupt flag when a send finishes or fails.

In peripheral mode a halted pipe makes the block answer each IN token with a STALL reply. A send written while the pipe is halted waits until the halt is removed. A reset command must carry two bits together to clear the halt and return the toggle to DATA0. If the packet engine never returns a handshake, an internal timer ends the attempt as a low-level error.

The control state machine has four states. `S_IDLE`: no send outstanding. `S_HOLD`: a send is queued but the pipe is halted. `S_ISSUE`: the request to the packet engine is raised for one cycle. `S_WAIT`: the block waits for a handshake or the timeout. Transitions: IDLE to ISSUE on a send command when the pipe is not halted. IDLE to HOLD on a send command when the pipe is halted. HOLD to ISSUE when the halt is cleared. ISSUE to WAIT always. WAIT to ISSUE on a NAK when the pipe is not halted. WAIT to HOLD on a NAK when the pipe is halted. WAIT to IDLE on ACK, STALL or ERR, or when the timeout expires.

Top module: `bulk_pipe_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `irq` is 0, `tx_req` is 0 and `tx_data1` is 0 (DATA0).
- R2: A command byte with bit 0 set, written while no send is outstanding and the pipe is not halted, raises `tx_req` for exactly one cycle. While `tx_req` is high, `tx_len` equals `buf_len` capped at MAX_PKT.
- R3: The handshake code is 0 for ACK, 1 for NAK, 2 for STALL and 3 for ERR. An ACK flips `tx_data1`, sets `irq` and returns the block to idle. A NAK leaves `tx_data1` unchanged, does not set `irq`, and raises `tx_req` again on the next cycle.
- R4: Command bit 4 halts the pipe, and status bit 4 then reads 1. While the pipe is halted in peripheral mode (`host_mode`=0), each `in_token` pulse gives a one-cycle `stall_reply` in the following cycle. In host mode, or when the pipe is not halted, `in_token` gives no `stall_reply`.
- R5: A command byte with bits 6 and 3 both set (48h) clears the halt and sets `tx_data1` to 0. Bit 6 alone (40h) or bit 3 alone (08h) leaves `tx_data1` and the halt unchanged.
- R6: An ERR handshake sets status bit 5 and `irq`, and leaves status bit 4 at 0.
- R7: A STALL handshake sets `irq`. It sets status bit 2 only in host mode; in peripheral mode status bit 2 stays 0.
- R8: If no handshake arrives within TIMEOUT_CYC cycles of waiting, status bit 5 and `irq` are set, the pipe is not halted, and no further request is raised.
- R9: A send command written while the pipe is halted raises no `tx_req` until a 48h command clears the halt. The request is then raised in the cycle after that command.
- R10: `irq` stays set until an `irq_ack` pulse clears it. Status bits 2 and 5 are cleared when a new send command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mode | input | 1 | 1 = host, 0 = peripheral |
| cmd_we | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte (bit 0 send, bit 4 halt, bits 6+3 reset) |
| status_byte | output | 8 | Status (bit 2 STALL seen, bit 4 halted, bit 5 error) |
| irq | output | 1 | Sticky completion interrupt flag |
| irq_ack | input | 1 | Clears `irq` |
| buf_len | input | LEN_W | Byte count held in the packet buffer |
| tx_req | output | 1 | One-cycle send request to the packet engine |
| tx_len | output | LEN_W | Packet length, capped at MAX_PKT |
| tx_data1 | output | 1 | Data toggle for the packet (0 DATA0, 1 DATA1) |
| hs_valid | input | 1 | Handshake from the packet engine is valid |
| hs_code | input | 2 | Handshake code: 0 ACK, 1 NAK, 2 STALL, 3 ERR |
| in_token | input | 1 | Peripheral IN token received for this pipe |
| stall_reply | output | 1 | Request to answer the IN token with STALL |

## Verification
A wrong toggle shows at `tx_data1` on the next request, and at the latest after the first ACK, because the value fails to flip or fails to return to DATA0 after a 48h command. A halt flag that is wrong shows within one cycle on status bit 4. In peripheral mode it also shows on the next IN token as a missing or extra `stall_reply`. A wrong state-machine state shows as a missing, repeated or early `tx_req`: a request leaks out while the pipe is halted, a NAK raises no new request, or the request stays low after a 48h command. A timer that is off by one moves the rise of status bit 5 by one cycle against the TIMEOUT_CYC window.

// File: rtl/bpc_pkg.sv
`timescale 1ns/1ps
package bpc_pkg;
    typedef enum logic [1:0] {
        HS_ACK   = 2'd0,
        HS_NAK   = 2'd1,
        HS_STALL = 2'd2,
        HS_ERR   = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HOLD,
        S_ISSUE,
        S_WAIT
    } st_e;

    localparam int CB_SEND = 0;
    localparam int CB_ARM  = 3;
    localparam int CB_HALT = 4;
    localparam int CB_RST  = 6;

    localparam int SB_STALL = 2;
    localparam int SB_HALT  = 4;
    localparam int SB_ERR   = 5;
endpackage

// File: rtl/bpc_toggle.sv
`timescale 1ns/1ps
module bpc_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic data1
);
    always_ff @(posedge clk) begin
        if (!rst_n)       data1 <= 1'b0;
        else if (clear)   data1 <= 1'b0;
        else if (advance) data1 <= ~data1;
    end

    // R5: a reset command forces DATA0 on the next cycle
    a_r5_clear_data0: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !data1);
endmodule

// File: rtl/bpc_timer.sv
`timescale 1ns/1ps
module bpc_timer #(
    parameter int TIMEOUT_CYC = 32,
    localparam int CW = $clog2(TIMEOUT_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (!expired)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/bpc_stall.sv
`timescale 1ns/1ps
module bpc_stall (
    input  logic clk,
    input  logic rst_n,
    input  logic in_token,
    input  logic halted,
    input  logic host_mode,
    output logic stall_reply
);
    always_ff @(posedge clk) begin
        if (!rst_n) stall_reply <= 1'b0;
        else        stall_reply <= in_token && halted && !host_mode;
    end

    // R4: STALL replies only follow an IN token on a halted peripheral pipe
    a_r4_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall_reply |-> $past(in_token && halted && !host_mode));
endmodule

// File: rtl/bulk_pipe_ctrl.sv
`timescale 1ns/1ps
module bulk_pipe_ctrl
    import bpc_pkg::*;
#(
    parameter int MAX_PKT     = 64,
    parameter int TIMEOUT_CYC = 32,
    localparam int LEN_W = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_byte,
    output logic [7:0]       status_byte,
    output logic             irq,
    input  logic             irq_ack,
    input  logic [LEN_W-1:0] buf_len,
    output logic             tx_req,
    output logic [LEN_W-1:0] tx_len,
    output logic             tx_data1,
    input  logic             hs_valid,
    input  logic [1:0]       hs_code,
    input  logic             in_token,
    output logic             stall_reply
);
    st_e  state_q, state_d;
    logic halt_q, halt_d;
    logic err_q, stall_q;
    logic send_cmd, halt_cmd, rst_cmd;
    logic hs_hit, timeout_hit, expired, wait_run, finish;
    logic unused_cmd_bits;

    assign send_cmd = cmd_we && cmd_byte[CB_SEND];
    assign halt_cmd = cmd_we && cmd_byte[CB_HALT];
    assign rst_cmd  = cmd_we && cmd_byte[CB_RST] && cmd_byte[CB_ARM];
    assign unused_cmd_bits = ^{cmd_byte[7], cmd_byte[5], cmd_byte[2:1]};

    always_comb begin
        if (halt_cmd)     halt_d = 1'b1;
        else if (rst_cmd) halt_d = 1'b0;
        else              halt_d = halt_q;
    end

    assign hs_hit      = (state_q == S_WAIT) && hs_valid;
    assign timeout_hit = (state_q == S_WAIT) && !hs_valid && expired;
    assign finish      = (hs_hit && hs_e'(hs_code) != HS_NAK) || timeout_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (send_cmd) state_d = halt_d ? S_HOLD : S_ISSUE;
            S_HOLD:  if (!halt_d)  state_d = S_ISSUE;
            S_ISSUE: state_d = S_WAIT;
            S_WAIT: begin
                if (hs_hit) begin
                    if (hs_e'(hs_code) == HS_NAK) state_d = halt_d ? S_HOLD : S_ISSUE;
                    else                          state_d = S_IDLE;
                end else if (timeout_hit) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        tx_req   = (state_q == S_ISSUE);
        wait_run = (state_q == S_WAIT);
        tx_len   = (buf_len > LEN_W'(MAX_PKT)) ? LEN_W'(MAX_PKT) : buf_len;
    end

    // flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= 1'b0;
            err_q   <= 1'b0;
            stall_q <= 1'b0;
            irq     <= 1'b0;
        end else begin
            halt_q <= halt_d;
            if (state_q == S_IDLE && send_cmd) begin
                err_q   <= 1'b0;
                stall_q <= 1'b0;
            end
            if ((hs_hit && hs_e'(hs_code) == HS_ERR) || timeout_hit) err_q <= 1'b1;
            if (hs_hit && hs_e'(hs_code) == HS_STALL && host_mode)   stall_q <= 1'b1;
            if (finish)       irq <= 1'b1;
            else if (irq_ack) irq <= 1'b0;
        end
    end

    always_comb begin
        status_byte           = 8'h00;
        status_byte[SB_STALL] = stall_q;
        status_byte[SB_HALT]  = halt_q;
        status_byte[SB_ERR]   = err_q;
    end

    bpc_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (rst_cmd),
        .advance (hs_hit && hs_e'(hs_code) == HS_ACK),
        .data1   (tx_data1)
    );

    bpc_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (expired)
    );

    bpc_stall u_stall (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_token    (in_token),
        .halted      (halt_q),
        .host_mode   (host_mode),
        .stall_reply (stall_reply)
    );

    // R2: the request is a single-cycle pulse
    a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> !tx_req);

    // R9: no request leaves while the pipe is halted
    a_r9_no_req_halted: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> !halt_q);

    // R3: an ACK without a reset command flips the toggle
    a_r3_ack_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_hit && hs_e'(hs_code) == HS_ACK && !rst_cmd) |=> (tx_data1 != $past(tx_data1)));

    // R3: a NAK on an unhalted pipe re-issues at once
    a_r3_nak_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_hit && hs_e'(hs_code) == HS_NAK && !halt_d) |=> tx_req);

    // R8: a timeout reports an error
    a_r8_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_hit |=> status_byte[SB_ERR]);

    // R10: the interrupt only rises from a transfer in progress
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state_q == S_WAIT));
endmodule

// File: tb/test_bulk_pipe_ctrl.sv
`timescale 1ns/1ps
module test_bulk_pipe_ctrl;
    localparam int MAXP  = 64;
    localparam int TO    = 32;
    localparam int LW    = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_mode = 1'b1;
    logic          cmd_we = 1'b0;
    logic [7:0]    cmd_byte = 8'h00;
    logic [7:0]    status_byte;
    logic          irq;
    logic          irq_ack = 1'b0;
    logic [LW-1:0] buf_len = '0;
    logic          tx_req;
    logic [LW-1:0] tx_len;
    logic          tx_data1;
    logic          hs_valid = 1'b0;
    logic [1:0]    hs_code = 2'd0;
    logic          in_token = 1'b0;
    logic          stall_reply;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bulk_pipe_ctrl #(.MAX_PKT(MAXP), .TIMEOUT_CYC(TO)) i_bulk_pipe_ctrl (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .cmd_we(cmd_we), .cmd_byte(cmd_byte), .status_byte(status_byte),
        .irq(irq), .irq_ack(irq_ack), .buf_len(buf_len),
        .tx_req(tx_req), .tx_len(tx_len), .tx_data1(tx_data1),
        .hs_valid(hs_valid), .hs_code(hs_code),
        .in_token(in_token), .stall_reply(stall_reply)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cmd(input logic [7:0] v);
        @(negedge clk);
        cmd_we = 1'b1; cmd_byte = v;
        @(negedge clk);
        cmd_we = 1'b0; cmd_byte = 8'h00;
    endtask

    task automatic handshake(input logic [1:0] c);
        hs_valid = 1'b1; hs_code = c;
        @(negedge clk);
        hs_valid = 1'b0;
    endtask

    task automatic pulse_in_token();
        @(negedge clk);
        in_token = 1'b1;
        @(negedge clk);
        in_token = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 status", status_byte, 8'h00);
        chk("R1 irq", irq, 0);
        chk("R1 tx_req", tx_req, 0);
        chk("R1 toggle", tx_data1, 0);
    endtask

    task automatic t_send_ack();
        host_mode = 1'b1; buf_len = LW'(10);
        write_cmd(8'h01);
        chk("R2 req raised", tx_req, 1);
        chk("R2 length", tx_len, 10);
        chk("R2 toggle DATA0", tx_data1, 0);
        @(negedge clk);
        chk("R2 req one cycle", tx_req, 0);
        handshake(2'd0);
        chk("R3 ack flips", tx_data1, 1);
        chk("R3 ack irq", irq, 1);
        chk("R3 ack status", status_byte, 8'h00);
        @(negedge clk);
        chk("R3 idle after ack", tx_req, 0);
        clear_irq();
        chk("R10 irq cleared", irq, 0);
    endtask

    task automatic t_nak_cap();
        buf_len = LW'(100);
        write_cmd(8'h01);
        chk("R2 length capped", tx_len, MAXP);
        @(negedge clk);
        handshake(2'd1);
        chk("R3 nak reissue", tx_req, 1);
        chk("R3 nak keeps toggle", tx_data1, 1);
        chk("R3 nak no irq", irq, 0);
        @(negedge clk);
        handshake(2'd0);
        chk("R3 ack after nak", tx_data1, 0);
        chk("R3 irq after nak", irq, 1);
        clear_irq();
    endtask

    task automatic t_halt_periph();
        host_mode = 1'b0;
        pulse_in_token();
        chk("R4 no stall unhalted", stall_reply, 0);
        write_cmd(8'h10);
        chk("R4 halted bit", status_byte[4], 1);
        pulse_in_token();
        chk("R4 stall reply", stall_reply, 1);
        @(negedge clk);
        chk("R4 stall one cycle", stall_reply, 0);
        write_cmd(8'h01);
        for (int i = 0; i < 5; i++) begin
            chk("R9 held while halted", tx_req, 0);
            @(negedge clk);
        end
        write_cmd(8'h48);
        chk("R9 released by reset", tx_req, 1);
        chk("R5 halt cleared", status_byte[4], 0);
        chk("R5 toggle DATA0", tx_data1, 0);
        @(negedge clk);
        handshake(2'd0);
        chk("R3 toggle after ack", tx_data1, 1);
        clear_irq();
        write_cmd(8'h40);
        chk("R5 bit6 alone keeps toggle", tx_data1, 1);
        write_cmd(8'h08);
        chk("R5 bit3 alone keeps toggle", tx_data1, 1);
        chk("R5 bit3 alone no halt", status_byte[4], 0);
        write_cmd(8'h10);
        host_mode = 1'b1;
        pulse_in_token();
        chk("R4 no stall in host mode", stall_reply, 0);
        write_cmd(8'h48);
        chk("R5 reset toggle", tx_data1, 0);
        chk("R5 reset unhalts", status_byte[4], 0);
    endtask

    task automatic t_err_stall();
        host_mode = 1'b1; buf_len = LW'(8);
        write_cmd(8'h01);
        @(negedge clk);
        handshake(2'd3);
        chk("R6 err bit", status_byte[5], 1);
        chk("R6 err irq", irq, 1);
        chk("R6 not halted", status_byte[4], 0);
        clear_irq();
        write_cmd(8'h01);
        chk("R10 send clears err", status_byte, 8'h00);
        @(negedge clk);
        handshake(2'd2);
        chk("R7 host stall bit", status_byte[2], 1);
        chk("R7 stall irq", irq, 1);
        clear_irq();
        host_mode = 1'b0;
        write_cmd(8'h01);
        chk("R10 send clears stall", status_byte, 8'h00);
        @(negedge clk);
        handshake(2'd2);
        chk("R7 periph no stall bit", status_byte[2], 0);
        chk("R7 periph stall irq", irq, 1);
        clear_irq();
    endtask

    task automatic t_timeout();
        host_mode = 1'b1;
        write_cmd(8'h01);
        @(negedge clk);
        repeat (TO - 1) @(negedge clk);
        chk("R8 no error before window", status_byte[5], 0);
        @(negedge clk);
        chk("R8 timeout error", status_byte[5], 1);
        chk("R8 timeout irq", irq, 1);
        chk("R8 timeout no halt", status_byte[4], 0);
        for (int i = 0; i < 4; i++) begin
            chk("R8 no request after timeout", tx_req, 0);
            @(negedge clk);
        end
        clear_irq();
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send_ack();
        t_nak_cap();
        t_halt_periph();
        t_err_stall();
        t_timeout();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule